// File: doc/BRIEF.md
# Garbling Session and Gate-Order Guard

This block sits at the front of a hardware garbling token and decides which parts of a circuit description the token may act on. Each session opens from a counter that only moves forward, and the session identifier is taken from that counter. The client's client-side reset cannot roll the counter back, so a session identifier can never be issued twice. After a session opens, the client streams the circuit description one record at a time. A header record gives the number of client input wires and the number of server input wires. Gate records follow, and then output records.

Gate labels must strictly increase. The first internal wire index is the sum of the two input counts. Because of this rule, a gate cannot be fed twice or out of order within a session. Any rejected record sets a sticky error for the session. At the end, a tag comparison made by an external authentication engine is presented once. The block grants key release only if the description reached its output section without an error and the comparison reports a match. The pseudorandom and authentication engines are outside this block.

Top module: `garble_guard`

## Requirements
- R1: Each accepted `sess_start` increments the session counter by one, and `sess_id` shows the new value from the next cycle. At the all-ones value, `sess_start` is ignored and the counter stays there. It never wraps.
- R2: `por_n` clears the counter to zero. `cli_rst_n` leaves `sess_id` unchanged, closes the session (`rec_ready` low) and clears `key_release` and `proto_err`.
- R3: Record kind encoding on `rec_kind` is 0 = header, 1 = gate, 2 = output, and 3 = reserved. Code 3 is always rejected. `rec_ready` is high only while an open session is still taking records. For a handshake (`rec_valid` and `rec_ready` both high), exactly one of `rec_accept` and `rec_reject` pulses in the following cycle. A record handshaken in the same cycle as an accepted `sess_start` is rejected without setting the error flag.
- R4: The first record of a session must be a header. Any other kind is rejected.
- R5: A header carries the client input count in `rec_a` and the server input count in `rec_b`. It is accepted only if their sum is at least 1 and at most 2^LBL_W-1. On acceptance, the last processed label becomes sum-1.
- R6: A gate record carries its label in `rec_a`. It is accepted only if the label is strictly greater than the last processed label, which it then becomes.
- R7: An output record carries a wire index in `rec_a`. It is accepted only if that index does not exceed the last processed label. Once an output record has been accepted, any further gate or header record is rejected.
- R8: Any rejected record raises `proto_err`. The flag holds until the next session starts or a client reset.
- R9: `key_release` rises the cycle after the session's first `tag_valid`, only if `tag_equal` is high, at least one output record has been accepted, and `proto_err` is low. It then stays high until the next session or a client reset. In every other case it stays low.
- R10: Only the first `tag_valid` of a session has any effect. After it, `rec_ready` drops and later tags are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the only reset of the session counter |
| cli_rst_n | input | 1 | Client reset, active low; clears session state only |
| sess_start | input | 1 | Session-start strobe |
| rec_valid | input | 1 | Record valid |
| rec_ready | output | 1 | Record ready; high while a session takes records |
| rec_kind | input | 2 | Record kind (0 header, 1 gate, 2 output, 3 reserved) |
| rec_a | input | LBL_W | Client input count, gate label, or output wire index |
| rec_b | input | LBL_W | Server input count (header only) |
| tag_valid | input | 1 | The external tag comparison result is present |
| tag_equal | input | 1 | Client tag matched the locally computed tag |
| sess_id | output | CTR_W | Current session identifier (counter value) |
| rec_accept | output | 1 | Pulse: previous record accepted |
| rec_reject | output | 1 | Pulse: previous record rejected |
| proto_err | output | 1 | Sticky session error |
| key_release | output | 1 | Output decryption key may be emitted |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. The accept or reject pulse follows the record handshake, the new `sess_id` follows the start strobe, and `key_release` follows the tag. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then samples on the next falling edge, compares against a requirement-level model of phase, last label and error, and deasserts the stimulus before the next edge. Random sessions with occasional out-of-order labels, illegal output indices and mismatched tags are mixed with directed cases: header sum bounds, the first-gate boundary at X+Y, client reset mid-session, repeated tags and counter saturation.

// File: rtl/garble_guard.sv
module garble_guard #(
  parameter int LBL_W = 16,
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cli_rst_n,
  input  logic             sess_start,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic [1:0]       rec_kind,
  input  logic [LBL_W-1:0] rec_a,
  input  logic [LBL_W-1:0] rec_b,
  input  logic             tag_valid,
  input  logic             tag_equal,
  output logic [CTR_W-1:0] sess_id,
  output logic             rec_accept,
  output logic             rec_reject,
  output logic             proto_err,
  output logic             key_release
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [1:0] K_HDR  = 2'd0;
  localparam logic [1:0] K_GATE = 2'd1;
  localparam logic [1:0] K_OUT  = 2'd2;

  typedef enum logic [2:0] {PH_IDLE, PH_HDR, PH_GATE, PH_OUT, PH_DONE} phase_t;

  phase_t           phase;
  logic [CTR_W-1:0] ctr;
  logic [LBL_W-1:0] last;
  logic             tag_used;
  logic             open_ok, hs, ok;
  logic [LBL_W:0]   sum;

  assign sess_id   = ctr;
  assign open_ok   = sess_start && (ctr != CTR_MAX);
  assign rec_ready = (phase == PH_HDR) || (phase == PH_GATE) || (phase == PH_OUT);
  assign hs        = rec_valid && rec_ready;
  assign sum       = {1'b0, rec_a} + {1'b0, rec_b};

  always_comb begin
    ok = 1'b0;
    case (phase)
      PH_HDR:  ok = (rec_kind == K_HDR) && (sum != '0) && !sum[LBL_W];
      PH_GATE: ok = ((rec_kind == K_GATE) && (rec_a > last)) ||
                    ((rec_kind == K_OUT) && (rec_a <= last));
      PH_OUT:  ok = (rec_kind == K_OUT) && (rec_a <= last);
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctr <= '0;
    else if (open_ok) ctr <= ctr + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n or negedge cli_rst_n) begin
    if (!por_n || !cli_rst_n) begin
      phase       <= PH_IDLE;
      last        <= '0;
      tag_used    <= 1'b0;
      proto_err   <= 1'b0;
      key_release <= 1'b0;
      rec_accept  <= 1'b0;
      rec_reject  <= 1'b0;
    end else begin
      rec_accept <= 1'b0;
      rec_reject <= 1'b0;
      if (open_ok) begin
        phase       <= PH_HDR;
        tag_used    <= 1'b0;
        proto_err   <= 1'b0;
        key_release <= 1'b0;
        rec_reject  <= hs;
      end else begin
        if (hs) begin
          rec_accept <= ok;
          rec_reject <= !ok;
          if (!ok) proto_err <= 1'b1;
          else begin
            case (rec_kind)
              K_HDR: begin
                last  <= sum[LBL_W-1:0] - 1'b1;
                phase <= PH_GATE;
              end
              K_GATE: last <= rec_a;
              default: phase <= PH_OUT;
            endcase
          end
        end
        if (tag_valid && !tag_used && phase != PH_IDLE && phase != PH_DONE) begin
          tag_used    <= 1'b1;
          phase       <= PH_DONE;
          key_release <= tag_equal && !proto_err && (phase == PH_OUT) && !(hs && !ok);
        end
      end
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) armed <= 1'b0;
    else armed <= 1'b1;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!por_n || !armed)
    (sess_start && sess_id != CTR_MAX) |=> (sess_id == $past(sess_id) + 1'b1)); // R1

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!por_n || !armed)
    !sess_start |=> $stable(sess_id)); // R2

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!por_n || !cli_rst_n || !armed)
    (rec_valid && rec_ready) |=> (rec_accept != rec_reject)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n || !cli_rst_n || !armed)
    (proto_err && !sess_start) |=> proto_err); // R8

  AST_KEY_CLEAN: assert property (@(posedge clk) disable iff (!por_n || !cli_rst_n || !armed)
    key_release |-> !proto_err); // R9

  AST_KEY_AFTER_TAG: assert property (@(posedge clk) disable iff (!por_n || !cli_rst_n || !armed)
    $rose(key_release) |-> $past(tag_valid)); // R10

endmodule

// File: tb/test_garble_guard.sv
module test_garble_guard;
  localparam int PER   = 10;
  localparam int LBL_W = 8;
  localparam int CTR_W = 6;
  localparam int LMAX  = (1 << LBL_W) - 1;
  localparam int CMAX  = (1 << CTR_W) - 1;

  logic clk = 1'b0;
  logic por_n, cli_rst_n, sess_start, rec_valid, tag_valid, tag_equal;
  logic [1:0] rec_kind;
  logic [LBL_W-1:0] rec_a, rec_b;
  logic rec_ready, rec_accept, rec_reject, proto_err, key_release;
  logic [CTR_W-1:0] sess_id;

  always #(PER/2) clk = ~clk;

  garble_guard #(.LBL_W(LBL_W), .CTR_W(CTR_W)) i_garble_guard (
    .clk(clk), .por_n(por_n), .cli_rst_n(cli_rst_n), .sess_start(sess_start),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind),
    .rec_a(rec_a), .rec_b(rec_b), .tag_valid(tag_valid), .tag_equal(tag_equal),
    .sess_id(sess_id), .rec_accept(rec_accept), .rec_reject(rec_reject),
    .proto_err(proto_err), .key_release(key_release));

  int n_chk = 0, n_bad = 0;
  int m_phase = 0, m_last = 0, m_id = 0;
  bit m_err = 0, m_key = 0, m_tagged = 0;
  int unsigned seed_v;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(int k, int a, int b);
    case (m_phase)
      1: return k == 0 && (a + b) >= 1 && (a + b) <= LMAX;
      2: return (k == 1 && a > m_last) || (k == 2 && a <= m_last);
      3: return k == 2 && a <= m_last;
      default: return 0;
    endcase
  endfunction

  task automatic rec(int k, int a, int b, string req);
    bit e;
    e = exp_ok(k, a, b);
    @(negedge clk);
    rec_valid = 1; rec_kind = 2'(k); rec_a = LBL_W'(a); rec_b = LBL_W'(b);
    @(posedge clk); @(negedge clk);
    rec_valid = 0;
    check({req, " ready"}, 1, 1);
    check({req, " accept"}, rec_accept, e);
    check({req, " reject"}, rec_reject, !e);
    if (!e) m_err = 1;
    else if (k == 0) begin m_last = a + b - 1; m_phase = 2; end
    else if (k == 1) m_last = a;
    else m_phase = 3;
    check("R8 err", proto_err, m_err);
  endtask

  task automatic start_sess();
    @(negedge clk); sess_start = 1;
    @(posedge clk); @(negedge clk); sess_start = 0;
    if (m_id != CMAX) begin
      m_id++; m_phase = 1; m_err = 0; m_key = 0; m_tagged = 0;
    end
    check("R1 sess_id", sess_id, m_id);
    check("R8 err cleared", proto_err, m_err);
    check("R3 ready", rec_ready, m_phase inside {1, 2, 3});
  endtask

  task automatic tag(bit eq, string req);
    @(negedge clk); tag_valid = 1; tag_equal = eq;
    @(posedge clk); @(negedge clk); tag_valid = 0;
    if (m_phase inside {1, 2, 3} && !m_tagged) begin
      m_tagged = 1; m_key = eq && m_phase == 3 && !m_err; m_phase = 4;
    end
    check({req, " key"}, key_release, m_key);
    check("R10 ready after tag", rec_ready, m_phase inside {1, 2, 3});
  endtask

  task automatic client_reset();
    @(negedge clk); cli_rst_n = 0;
    @(posedge clk); @(negedge clk); cli_rst_n = 1;
    m_phase = 0; m_err = 0; m_key = 0;
    check("R2 id kept", sess_id, m_id);
    check("R2 ready low", rec_ready, 0);
    check("R2 key low", key_release, 0);
  endtask

  initial begin
    #(PER * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_v = 32'd7;
    void'($urandom(seed_v));
    por_n = 0; cli_rst_n = 1; sess_start = 0; rec_valid = 0; tag_valid = 0;
    tag_equal = 0; rec_kind = 0; rec_a = 0; rec_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1;
    @(negedge clk);
    check("R2 reset id", sess_id, 0);
    check("R3 reset ready", rec_ready, 0);
    check("R9 reset key", key_release, 0);

    // R4 / R3 directed
    start_sess();
    rec(1, 5, 0, "R4 gate first");
    rec(3, 0, 0, "R3 reserved kind");
    tag(1, "R9 error blocks key");
    // R5 bounds and R6 first gate boundary
    start_sess();
    rec(0, 0, 0, "R5 zero sum");
    start_sess();
    rec(0, LMAX, 1, "R5 overflow sum");
    start_sess();
    rec(0, 2, 3, "R5 header");
    rec(1, 4, 0, "R6 label X+Y-1");
    start_sess();
    rec(0, 2, 3, "R5 header");
    rec(1, 5, 0, "R6 label X+Y");
    rec(1, 5, 0, "R6 repeat label");
    // R7 ordering and index bound
    start_sess();
    rec(0, 1, 1, "R5 header");
    rec(1, 3, 0, "R6 gate");
    rec(2, 4, 0, "R7 index too high");
    start_sess();
    rec(0, 1, 1, "R5 header");
    rec(1, 3, 0, "R6 gate");
    rec(2, 3, 0, "R7 output");
    rec(1, 9, 0, "R7 gate after output");
    // R9 no outputs, R10 second tag
    start_sess();
    rec(0, 1, 2, "R5 header");
    rec(1, 4, 0, "R6 gate");
    tag(1, "R9 no outputs");
    tag(1, "R10 second tag");
    start_sess();
    rec(0, 1, 2, "R5 header");
    rec(2, 1, 0, "R7 output");
    tag(0, "R9 mismatch");
    tag(1, "R10 late match");
    start_sess();
    rec(0, 1, 2, "R5 header");
    rec(2, 2, 0, "R7 output");
    tag(1, "R9 clean match");
    // R2 client reset mid session
    start_sess();
    rec(0, 3, 3, "R5 header");
    client_reset();
    tag(1, "R10 tag outside session");

    // random sessions
    for (int s = 0; s < 30; s++) begin
      int x, y, lbl, ng, no;
      start_sess();
      x = $urandom % 6; y = $urandom % 6;
      if ($urandom % 10 == 0) x = 0;
      rec(0, x, y, "R5 rand header");
      lbl = x + y - 1;
      ng = $urandom % 8;
      for (int g = 0; g < ng; g++) begin
        int nl;
        nl = lbl + 1 + ($urandom % 4);
        if ($urandom % 12 == 0) nl = lbl;
        if (nl > LMAX) nl = LMAX;
        if (m_phase inside {1, 2, 3}) rec(1, nl, 0, "R6 rand gate");
        if (nl > lbl) lbl = nl;
      end
      no = $urandom % 3;
      for (int o = 0; o < no; o++) begin
        int w;
        w = (lbl > 0) ? ($urandom % (lbl + 1)) : 0;
        if ($urandom % 10 == 0) w = lbl + 1;
        if (m_phase inside {1, 2, 3}) rec(2, w, 0, "R7 rand output");
      end
      tag($urandom % 4 != 0, "R9 rand tag");
    end

    // R1 saturation
    while (m_id < CMAX) start_sess();
    start_sess();
    check("R1 saturated id", sess_id, CMAX);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule